// File: doc/BRIEF.md
# Halfword-Aware Instruction Fetch Unit

This block sits between a 32-bit core's program counter and a word-wide instruction bus. The core may mix 16-bit compressed instructions with 32-bit ones, so an instruction can start on either halfword of a bus word. For each instruction the unit does three things. First, it samples the program counter and issues word-aligned read requests over a valid/ready handshake. Second, it picks the halfword where the instruction begins. Third, when a full-width instruction starts in the upper halfword, it fetches the following word and joins the two halves.

The finished instruction goes to the decoder together with a flag that marks compressed encodings. The unit then holds that instruction steady and stops using the bus until the decoder reports that it is done with it. After that report the unit samples the program counter again and starts the next instruction. Decompression, prediction and caching belong to other blocks.

Top module: `ifetch_unit`

## Requirements
- R1: A bus word is taken only at a rising clock edge where both `bus_valid` and `bus_ready` are high. A `bus_valid` pulse while `bus_ready` is low changes neither the presented instruction nor the number of words taken.
- R2: When bit 1 of the sampled program counter is 0, exactly one word is fetched, from the program counter with bits [1:0] cleared.
- R3: When bit 1 of the sampled program counter is 1 and the upper halfword of the fetched word is compressed, exactly one word is fetched. The instruction is that upper halfword.
- R4: When bit 1 is 1 and the upper halfword is not compressed, two words are fetched: first from the aligned address, then from the aligned address plus 4. The instruction is {second word [15:0], first word [31:16]}.
- R5: The first halfword of an instruction marks it as compressed (`instr_is_c` = 1) when its bits [1:0] are anything other than 2'b11. When they are 2'b11 the instruction is full width and `instr_is_c` = 0.
- R6: While `instr_valid` is high, `bus_ready` stays low and the instruction and flag stay unchanged. This holds until a cycle in which `decode_done` is high. After that cycle the unit drops `instr_valid` and starts the next instruction.
- R7: A compressed instruction appears on `instr_out[15:0]`, and `instr_out[31:16]` is zero.
- R8: While `rst` is high at a clock edge, the next cycle shows `instr_valid` = 0 and `bus_ready` = 0.
- R9: The program counter is sampled once, in the first cycle after reset or after a decode-done cycle. Changes to `next_pc` after that point do not affect the addresses or the result of the instruction in progress.
- R10: A reset during a split fetch discards the half-built instruction. The first instruction after reset is built only from words fetched after reset.
- R11: No instruction ever takes more than two bus words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| next_pc | input | ADDR_W | Program counter of the next instruction |
| bus_addr | output | ADDR_W | Word-aligned fetch address |
| bus_rdata | input | 32 | Word returned by the instruction bus |
| bus_valid | input | 1 | Bus data valid |
| bus_ready | output | 1 | Unit is ready to take a bus word |
| instr_out | output | 32 | Assembled instruction |
| instr_is_c | output | 1 | Instruction is 16-bit compressed |
| instr_valid | output | 1 | Instruction is presented to the decoder |
| decode_done | input | 1 | Decoder has finished with the presented instruction |

## Verification
The bench builds the unit with the default ADDR_W of 32. It uses a small word store at the bottom of the address space, so every halfword-offset case lies within an eight-word window: aligned full, aligned compressed, upper compressed, and split across two words, including the split case whose second word sits at the next eight-byte step. Its bus model inserts 0 to 4 wait cycles per word. This delays the second word of a split and lets a reset land between the two fetches. Stray valid pulses are injected while the unit is holding an instruction.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    localparam int INSTR_W = 32;
    localparam int HALF_W  = INSTR_W / 2;

    typedef enum logic [1:0] {
        ST_LOAD     = 2'd0,
        ST_FETCH_LO = 2'd1,
        ST_FETCH_HI = 2'd2,
        ST_HOLD     = 2'd3
    } fetch_st_e;

    typedef struct packed {
        logic [INSTR_W-1:0] bits;
        logic               is_c;
    } instr_rec_t;

    // a halfword opens a compressed instruction unless its two low bits are both set
    function automatic logic half_is_compressed(input logic [HALF_W-1:0] h);
        return h[1:0] != 2'b11;
    endfunction

    function automatic logic [INSTR_W-1:0] widen_half(input logic [HALF_W-1:0] h);
        return {{(INSTR_W-HALF_W){1'b0}}, h};
    endfunction

endpackage

// File: rtl/ifu_pc_hold.sv
module ifu_pc_hold #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic              use_second,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              upper_sel
);
    localparam int WORD_BYTES = 4;
    localparam int LOW_BITS   = $clog2(WORD_BYTES);

    logic [ADDR_W-1:LOW_BITS] word_q;
    logic                     upper_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            upper_q <= 1'b0;
        end else if (load_en) begin
            word_q  <= pc_in[ADDR_W-1:LOW_BITS];
            upper_q <= pc_in[1];
        end
    end

    logic [ADDR_W-1:LOW_BITS] word_sel;
    always_comb begin
        word_sel = use_second ? word_q + 1'b1 : word_q;
    end

    assign fetch_addr = {word_sel, {LOW_BITS{1'b0}}};
    assign upper_sel  = upper_q;

endmodule

// File: rtl/ifu_seq.sv
module ifu_seq
    import ifu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bus_valid,
    input  logic      decode_done,
    input  logic      upper_sel,
    input  logic      first_full,
    output fetch_st_e state,
    output logic      pc_load,
    output logic      bus_ready,
    output logic      take_lo,
    output logic      take_hi,
    output logic      use_second,
    output logic      instr_valid
);
    fetch_st_e st_q, st_d;
    logic      accept;

    assign bus_ready   = (st_q == ST_FETCH_LO) || (st_q == ST_FETCH_HI);
    assign accept      = bus_ready && bus_valid;
    assign take_lo     = accept && (st_q == ST_FETCH_LO);
    assign take_hi     = accept && (st_q == ST_FETCH_HI);
    assign pc_load     = (st_q == ST_LOAD);
    assign use_second  = (st_q == ST_FETCH_HI);
    assign instr_valid = (st_q == ST_HOLD);
    assign state       = st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LOAD:     st_d = ST_FETCH_LO;
            ST_FETCH_LO: begin
                if (accept) begin
                    st_d = (upper_sel && first_full) ? ST_FETCH_HI : ST_HOLD;
                end
            end
            ST_FETCH_HI: begin
                if (accept) begin
                    st_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (decode_done) begin
                    st_d = ST_LOAD;
                end
            end
            default:     st_d = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_LOAD;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ifu_assemble.sv
module ifu_assemble
    import ifu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] rdata,
    input  logic               upper_sel,
    input  logic               take_lo,
    input  logic               take_hi,
    output logic               first_full,
    output instr_rec_t         instr
);
    logic [HALF_W-1:0] first_half;
    logic [HALF_W-1:0] pend_q;
    instr_rec_t        rec_q;

    always_comb begin
        first_half = upper_sel ? rdata[INSTR_W-1:HALF_W] : rdata[HALF_W-1:0];
        first_full = !half_is_compressed(first_half);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            rec_q  <= '0;
        end else if (take_lo) begin
            pend_q <= first_half;
            if (!first_full) begin
                rec_q.bits <= widen_half(first_half);
                rec_q.is_c <= 1'b1;
            end else if (!upper_sel) begin
                rec_q.bits <= rdata;
                rec_q.is_c <= 1'b0;
            end
        end else if (take_hi) begin
            rec_q.bits <= {rdata[HALF_W-1:0], pend_q};
            rec_q.is_c <= 1'b0;
        end
    end

    assign instr = rec_q;

endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
    import ifu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] next_pc,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_valid,
    output logic              bus_ready,
    output logic [31:0]       instr_out,
    output logic              instr_is_c,
    output logic              instr_valid,
    input  logic              decode_done
);
    fetch_st_e  state;
    logic       pc_load;
    logic       take_lo;
    logic       take_hi;
    logic       use_second;
    logic       upper_sel;
    logic       first_full;
    instr_rec_t instr;

    ifu_pc_hold #(.ADDR_W(ADDR_W)) pc_i (
        .clk        (clk),
        .rst        (rst),
        .load_en    (pc_load),
        .pc_in      (next_pc),
        .use_second (use_second),
        .fetch_addr (bus_addr),
        .upper_sel  (upper_sel)
    );

    ifu_seq seq_i (
        .clk         (clk),
        .rst         (rst),
        .bus_valid   (bus_valid),
        .decode_done (decode_done),
        .upper_sel   (upper_sel),
        .first_full  (first_full),
        .state       (state),
        .pc_load     (pc_load),
        .bus_ready   (bus_ready),
        .take_lo     (take_lo),
        .take_hi     (take_hi),
        .use_second  (use_second),
        .instr_valid (instr_valid)
    );

    ifu_assemble asm_i (
        .clk        (clk),
        .rst        (rst),
        .rdata      (bus_rdata),
        .upper_sel  (upper_sel),
        .take_lo    (take_lo),
        .take_hi    (take_hi),
        .first_full (first_full),
        .instr      (instr)
    );

    assign instr_out  = instr.bits;
    assign instr_is_c = instr.is_c;

endmodule

// File: rtl/ifetch_unit_chk.sv
module ifetch_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] next_pc,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic [31:0]       instr_out,
    input logic              instr_is_c,
    input logic              instr_valid,
    input logic              decode_done
);
    logic [1:0]        beats_q;
    logic [ADDR_W-1:0] first_addr_q;
    logic              accept;

    assign accept = bus_valid && bus_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            beats_q      <= '0;
            first_addr_q <= '0;
        end else if (instr_valid && decode_done) begin
            beats_q <= '0;
        end else if (accept) begin
            beats_q <= (beats_q == 2'd3) ? beats_q : beats_q + 1'b1;
            if (beats_q == 2'd0) begin
                first_addr_q <= bus_addr;
            end
        end
    end

    // R6
    hold_ready_low_chk: assert property (@(posedge clk) disable iff (rst)
        instr_valid |-> !bus_ready);

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !decode_done) |=> (instr_valid && $stable(instr_out) && $stable(instr_is_c)));

    // R6
    release_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && decode_done) |=> !instr_valid);

    // R7
    compressed_zero_top_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_is_c) |-> (instr_out[31:16] == 16'h0000));

    // R5
    flag_encoding_chk: assert property (@(posedge clk) disable iff (rst)
        instr_valid |-> (instr_is_c == (instr_out[1:0] != 2'b11)));

    // R11
    beat_count_chk: assert property (@(posedge clk) disable iff (rst)
        instr_valid |-> ((beats_q == 2'd1) || (beats_q == 2'd2)));

    // R4
    split_full_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && beats_q == 2'd2) |-> !instr_is_c);

    // R4
    second_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && beats_q == 2'd1) |-> (bus_addr == first_addr_q + ADDR_W'(4)));

    // R2
    aligned_addr_chk: assert property (@(posedge clk) disable iff (rst)
        bus_ready |-> (bus_addr[1:0] == 2'b00));

    // R8
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!instr_valid && !bus_ready));

    logic unused_ok;
    assign unused_ok = ^{next_pc, bus_rdata};

endmodule

bind ifetch_unit ifetch_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .next_pc     (next_pc),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .bus_valid   (bus_valid),
    .bus_ready   (bus_ready),
    .instr_out   (instr_out),
    .instr_is_c  (instr_is_c),
    .instr_valid (instr_valid),
    .decode_done (decode_done)
);

// File: tb/ifetch_unit_tb_top.sv
`timescale 1ns/1ps
module ifetch_unit_tb_top;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] next_pc = '0;
    logic [ADDR_W-1:0] bus_addr;
    logic [31:0]       bus_rdata = '0;
    logic              bus_valid = 1'b0;
    logic              bus_ready;
    logic [31:0]       instr_out;
    logic              instr_is_c;
    logic              instr_valid;
    logic              decode_done = 1'b0;

    int total = 0;
    int bad = 0;
    int latency = 0;
    int wait_cnt = 0;
    int acc_cnt = 0;
    logic stray = 1'b0;
    logic [ADDR_W-1:0] acc_addr [0:3];
    logic [31:0] mem [0:7];

    always #2.5 clk = ~clk;

    ifetch_unit #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst), .next_pc(next_pc), .bus_addr(bus_addr),
        .bus_rdata(bus_rdata), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .instr_out(instr_out), .instr_is_c(instr_is_c), .instr_valid(instr_valid),
        .decode_done(decode_done)
    );

    // bus model: answers after `latency` idle cycles, drives away from the active edge
    always @(negedge clk) begin
        if (stray) begin
            bus_valid = 1'b1;
            bus_rdata = 32'hDEAD_BEEF;
        end else if (bus_ready) begin
            if (wait_cnt >= latency) begin
                bus_valid = 1'b1;
                bus_rdata = mem[bus_addr[4:2]];
                wait_cnt  = 0;
            end else begin
                bus_valid = 1'b0;
                wait_cnt  = wait_cnt + 1;
            end
        end else begin
            bus_valid = 1'b0;
            wait_cnt  = 0;
        end
    end

    always @(posedge clk) begin
        if (bus_valid && bus_ready) begin
            if (acc_cnt < 4) acc_addr[acc_cnt] = bus_addr;
            acc_cnt = acc_cnt + 1;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 60; i++) begin
            if (instr_valid) break;
            @(negedge clk);
        end
    endtask

    task automatic start_next(input logic [ADDR_W-1:0] pc, input int lat);
        @(negedge clk);
        next_pc     = pc;
        latency     = lat;
        decode_done = 1'b1;
        @(negedge clk);
        decode_done = 1'b0;
        acc_cnt     = 0;
        @(negedge clk);
        next_pc     = 32'hFFFF_FFF2;   // R9: later changes must not matter
    endtask

    task automatic expect_instr(input string tag, input logic [31:0] exp_i, input logic exp_c,
                                input int exp_n, input logic [31:0] a0, input logic [31:0] a1);
        wait_valid();
        check(instr_valid, {tag, " valid"}, {31'b0, instr_valid}, 32'h1);
        check(instr_out == exp_i, {tag, " instr"}, instr_out, exp_i);
        check(instr_is_c == exp_c, {tag, " R5 flag"}, {31'b0, instr_is_c}, {31'b0, exp_c});
        check(acc_cnt == exp_n, {tag, " R11 beats"}, acc_cnt, exp_n);
        check(acc_addr[0] == a0, {tag, " R9 addr0"}, acc_addr[0], a0);
        if (exp_n == 2) check(acc_addr[1] == a1, {tag, " R4 addr1"}, acc_addr[1], a1);
        // R6: hold steady with the bus idle
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(instr_valid && !bus_ready && instr_out == exp_i, {tag, " R6 hold"},
                  instr_out, exp_i);
        end
    endtask

    task automatic test_reset_state();
        rst = 1'b1;
        next_pc = 32'h0;
        repeat (3) @(negedge clk);
        check(!instr_valid && !bus_ready, "R8 reset idle", {30'b0, instr_valid, bus_ready}, 32'h0);
        rst = 1'b0;
        acc_cnt = 0;
        latency = 0;
        @(negedge clk);
        next_pc = 32'hFFFF_FFF2;
        expect_instr("R2 aligned full", 32'h00A5_0513, 1'b0, 1, 32'h0, 32'h0);
    endtask

    task automatic test_aligned_compressed();
        start_next(32'h4, 1);
        expect_instr("R2 R7 aligned compressed", 32'h0000_4501, 1'b1, 1, 32'h4, 32'h0);
    endtask

    task automatic test_upper_compressed();
        start_next(32'h6, 2);
        expect_instr("R3 upper compressed", 32'h0000_4585, 1'b1, 1, 32'h4, 32'h0);
        start_next(32'hA, 0);
        expect_instr("R3 R7 upper compressed b", 32'h0000_1234, 1'b1, 1, 32'h8, 32'h0);
    endtask

    task automatic test_split();
        start_next(32'hE, 3);
        expect_instr("R4 split", 32'h00C5_0293, 1'b0, 2, 32'hC, 32'h10);
        start_next(32'h14, 0);
        expect_instr("R2 all ones", 32'hFFFF_FFFF, 1'b0, 1, 32'h14, 32'h0);
        start_next(32'h16, 2);
        expect_instr("R4 R11 split b", 32'hABCF_FFFF, 1'b0, 2, 32'h14, 32'h18);
    endtask

    task automatic test_stray_valid();
        logic [31:0] held;
        held = instr_out;
        @(negedge clk);
        stray = 1'b1;
        repeat (3) @(negedge clk);
        stray = 1'b0;
        @(negedge clk);
        check(acc_cnt == 2, "R1 stray beats", acc_cnt, 2);
        check(instr_out == held && instr_valid, "R1 stray instr", instr_out, held);
    endtask

    task automatic test_reset_mid_split();
        start_next(32'hE, 4);
        for (int i = 0; i < 40; i++) begin
            if (acc_cnt == 1) break;
            @(negedge clk);
        end
        check(acc_cnt == 1, "R10 first beat", acc_cnt, 1);
        rst = 1'b1;
        next_pc = 32'h4;
        @(negedge clk);
        check(!instr_valid && !bus_ready, "R8 mid reset", {30'b0, instr_valid, bus_ready}, 32'h0);
        rst = 1'b0;
        acc_cnt = 0;
        latency = 1;
        @(negedge clk);
        next_pc = 32'hFFFF_FFF2;
        expect_instr("R10 after reset", 32'h0000_4501, 1'b1, 1, 32'h4, 32'h0);
    endtask

    logic finished = 1'b0;

    initial begin
        mem[0] = 32'h00A5_0513;
        mem[1] = 32'h4585_4501;
        mem[2] = 32'h1234_4601;
        mem[3] = 32'h0293_4681;
        mem[4] = 32'h9999_00C5;
        mem[5] = 32'hFFFF_FFFF;
        mem[6] = 32'h0000_ABCF;
        mem[7] = 32'h0000_0000;
        for (int i = 0; i < 4; i++) acc_addr[i] = '0;
        test_reset_state();
        test_aligned_compressed();
        test_upper_compressed();
        test_split();
        test_stray_valid();
        test_reset_mid_split();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule